// File: doc/BRIEF.md
# CMAC Hypercube Address Generator

This block turns a quantized two-dimensional coordinate into the memory indices of every hypercube that the coordinate activates in a layered CMAC associative memory. Each layer displaces the coordinate by its own offset, groups the displaced value into coarse blocks of width equal to the layer count, and merges the x and y block numbers into a linear index. Each layer's indices fall in their own contiguous region of one flat weight memory. All layer indices come out side by side, so a weight memory can read or update all active cells in the same cycle.

The default configuration has four layers and seventeen states per axis. That gives five blocks per axis, twenty-five hypercubes per layer and one hundred indices in total. Division by the layer count is a right shift, so the layer count must be a power of two. A coordinate above the last valid state raises a range flag, and the indices are meaningless while that flag is set. A parameter selects either a registered output stage or a purely combinational path. When the stage is registered, it captures the indices only on cycles that carry a valid input.

Top module: `cmac_addr_gen`

## Requirements
- R1: For layer j (j = 1..4), the block number on each axis is floor((coordinate + j - 1) / 4), with coordinates 0..16.
- R2: The layer-j index equals bx + 5*by + 25*(j - 1). It is placed in hc_index bits [7*j-1 : 7*(j-1)], so layer 1 is in the lowest 7 bits.
- R3: For any in-range coordinate, the layer-j index lies between 25*(j-1) and 25*j - 1.
- R4: Input (9,0) yields indices 2, 27, 52, 78. Input (9,1) yields 2, 27, 52, 83. Input (9,2) yields 2, 27, 57, 83. Each list runs from layer 1 to layer 4.
- R5: Corner (0,0) yields 0, 25, 50, 75 and corner (16,16) yields 24, 49, 74, 99.
- R6: out_of_range is 1 when either coordinate exceeds 16 and 0 otherwise. It is presented with the same timing as the indices.
- R7: With the registered stage (the default), out_valid, hc_index and out_of_range reflect the input that was applied with in_valid high one clock earlier. Back-to-back valid inputs each appear in the following cycle.
- R8: With the registered stage, a cycle with in_valid low leaves hc_index and out_of_range unchanged and drives out_valid low on the next edge.
- R9: During a synchronous reset (rst_n low at a clock edge), out_valid, hc_index and out_of_range are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Coordinate pair is valid this cycle |
| x_coord | input | 5 | Quantized x coordinate |
| y_coord | input | 5 | Quantized y coordinate |
| out_valid | output | 1 | Indices are valid |
| out_of_range | output | 1 | A coordinate exceeded the last state |
| hc_index | output | 28 | Four 7-bit hypercube indices, layer 1 lowest |

## Verification
The bench applies all 289 in-range coordinates against a model that uses integer division. This full sweep catches any wrong offset, block width or layer base, and any wrong field placement. Separate tests cover the three published sample points and the two grid corners. The corners fix the lowest and highest index of every layer region. Further tests drive coordinates just above the valid range on each axis separately and present valid inputs back to back. They also change the inputs while in_valid is low, which separates correct capture from a stage that samples on every cycle or one that adds a cycle of delay.

// File: rtl/cmac_addr_pkg.sv
// Package: shared sizing helpers for the CMAC address generator.
// Assumes the layer count is a power of two and at least 1.
package cmac_addr_pkg;

    // Number of coarse blocks per axis once the largest layer offset is applied.
    function automatic int blocks_per_axis(input int states, input int layers);
        return (states - 1 + layers - 1) / layers + 1;
    endfunction

    // Total number of hypercubes over all layers.
    function automatic int total_cells(input int states, input int layers);
        return layers * blocks_per_axis(states, layers) * blocks_per_axis(states, layers);
    endfunction

endpackage

// File: rtl/cmac_axis_quant.sv
// Module: cmac_axis_quant
// Shifts one coordinate by a fixed layer offset and quantizes it into a
// coarse block number by a right shift. Assumes the block width is a power
// of two (given as SHIFT). For a coordinate above the last state the output
// is truncated and carries no meaning.
module cmac_axis_quant #(
    parameter int COORD_W = 5,
    parameter int STATES  = 17,
    parameter int SHIFT   = 2,
    parameter int OFFSET  = 0,
    parameter int BLOCKS  = 5,
    parameter int BLK_W   = 3
) (
    input  logic [COORD_W-1:0] coord,
    output logic [BLK_W-1:0]   blk
);
    localparam int SUM_W = COORD_W + 1;

    logic [SUM_W-1:0] shifted_sum;
    logic [SUM_W-1:0] quotient;

    // Offset then divide by the block width.
    always_comb begin
        shifted_sum = {1'b0, coord} + SUM_W'(OFFSET);
        quotient    = shifted_sum >> SHIFT;
        blk         = BLK_W'(quotient);
    end

    // An in-range coordinate must land in an existing block (R1).
    always_comb begin
        if (!$isunknown(coord) && (int'(coord) < STATES)) begin
            assert_block_in_grid_R1: assert (int'(quotient) < BLOCKS)
                else $error("block number %0d outside grid", quotient);
        end
    end
endmodule

// File: rtl/cmac_layer_index.sv
// Module: cmac_layer_index
// Computes the linear hypercube index for one layer: the x block number plus
// the y block number times the blocks per axis, plus this layer's base in
// the flat weight memory. LAYER is 0-based, and its offset equals LAYER.
module cmac_layer_index #(
    parameter int COORD_W = 5,
    parameter int STATES  = 17,
    parameter int SHIFT   = 2,
    parameter int LAYER   = 0,
    parameter int BLOCKS  = 5,
    parameter int IDX_W   = 7
) (
    input  logic [COORD_W-1:0] x_coord,
    input  logic [COORD_W-1:0] y_coord,
    output logic [IDX_W-1:0]   index
);
    localparam int BLK_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
    localparam int REGION = BLOCKS * BLOCKS;
    localparam logic [IDX_W-1:0] BASE = IDX_W'(LAYER * REGION);

    logic [BLK_W-1:0] bx;
    logic [BLK_W-1:0] by;

    cmac_axis_quant #(
        .COORD_W(COORD_W), .STATES(STATES), .SHIFT(SHIFT),
        .OFFSET(LAYER), .BLOCKS(BLOCKS), .BLK_W(BLK_W)
    ) u_qx (
        .coord(x_coord),
        .blk  (bx)
    );

    cmac_axis_quant #(
        .COORD_W(COORD_W), .STATES(STATES), .SHIFT(SHIFT),
        .OFFSET(LAYER), .BLOCKS(BLOCKS), .BLK_W(BLK_W)
    ) u_qy (
        .coord(y_coord),
        .blk  (by)
    );

    // Merge the two block numbers into this layer's region.
    always_comb begin
        index = BASE + IDX_W'(bx) + IDX_W'(by) * IDX_W'(BLOCKS);
    end

    // For in-range inputs the index stays inside this layer's region (R3).
    always_comb begin
        if (!$isunknown({x_coord, y_coord}) &&
            (int'(x_coord) < STATES) && (int'(y_coord) < STATES)) begin
            assert_index_in_region_R3: assert ((int'(index) >= LAYER * REGION) &&
                                               (int'(index) <  (LAYER + 1) * REGION))
                else $error("layer %0d index %0d outside region", LAYER, index);
        end
    end
endmodule

// File: rtl/cmac_index_stage.sv
// Module: cmac_index_stage
// Optional output stage. If PIPELINED is nonzero, data is captured on
// cycles with in_valid high and held otherwise, and valid is delayed by one
// cycle. The stage uses a synchronous active-low reset. If PIPELINED is zero,
// the stage is a wire.
module cmac_index_stage #(
    parameter int WIDTH     = 29,
    parameter bit PIPELINED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] din,
    output logic             out_valid,
    output logic [WIDTH-1:0] dout
);
    if (PIPELINED) begin : g_reg
        logic             valid_q;
        logic [WIDTH-1:0] data_q;

        // Valid follows the input one cycle later.
        always_ff @(posedge clk) begin
            if (!rst_n) valid_q <= 1'b0;
            else        valid_q <= in_valid;
        end

        // Data is captured only with a valid input.
        always_ff @(posedge clk) begin
            if (!rst_n)        data_q <= '0;
            else if (in_valid) data_q <= din;
        end

        assign out_valid = valid_q;
        assign dout      = data_q;

        assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        assert_idle_drops_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        assert_idle_holds_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(dout));
        assert_captures_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (dout == $past(din)));
    end else begin : g_wire
        assign out_valid = in_valid;
        assign dout      = din;
    end
endmodule

// File: rtl/cmac_addr_gen.sv
// Module: cmac_addr_gen (top)
// Produces all NUM_LAYERS hypercube indices of a 2-D CMAC in parallel for
// one coordinate pair, and flags coordinates beyond the last state.
// Assumes NUM_LAYERS is a power of two. Layer 1 is in the lowest field of
// hc_index.
module cmac_addr_gen #(
    parameter int NUM_LAYERS = 4,
    parameter int STATES     = 17,
    parameter bit PIPELINED  = 1'b1,
    parameter int COORD_W    = $clog2(STATES),
    parameter int IDX_W      = $clog2(cmac_addr_pkg::total_cells(STATES, NUM_LAYERS))
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [COORD_W-1:0]          x_coord,
    input  logic [COORD_W-1:0]          y_coord,
    output logic                        out_valid,
    output logic                        out_of_range,
    output logic [NUM_LAYERS*IDX_W-1:0] hc_index
);
    localparam int SHIFT   = $clog2(NUM_LAYERS);
    localparam int BLOCKS  = cmac_addr_pkg::blocks_per_axis(STATES, NUM_LAYERS);
    localparam int STAGE_W = NUM_LAYERS * IDX_W + 1;
    localparam logic [COORD_W-1:0] LAST = COORD_W'(STATES - 1);

    logic [NUM_LAYERS*IDX_W-1:0] idx_comb;
    logic                        oor_comb;
    logic [STAGE_W-1:0]          stage_out;

    // One index generator per layer.
    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        cmac_layer_index #(
            .COORD_W(COORD_W), .STATES(STATES), .SHIFT(SHIFT),
            .LAYER(l), .BLOCKS(BLOCKS), .IDX_W(IDX_W)
        ) u_layer (
            .x_coord(x_coord),
            .y_coord(y_coord),
            .index  (idx_comb[l*IDX_W +: IDX_W])
        );
    end

    // Range check on both axes.
    always_comb begin
        oor_comb = (x_coord > LAST) || (y_coord > LAST);
    end

    cmac_index_stage #(
        .WIDTH(STAGE_W), .PIPELINED(PIPELINED)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .din      ({oor_comb, idx_comb}),
        .out_valid(out_valid),
        .dout     (stage_out)
    );

    assign out_of_range = stage_out[STAGE_W-1];
    assign hc_index     = stage_out[STAGE_W-2:0];

    if (PIPELINED) begin : g_chk
        assert_flag_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && ((x_coord > LAST) || (y_coord > LAST))) |=> out_of_range);
        assert_flag_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (x_coord <= LAST) && (y_coord <= LAST)) |=> !out_of_range);
    end
endmodule

// File: tb/cmac_addr_gen_test.sv
`timescale 1ns/1ps
module cmac_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  x_coord = '0;
    logic [4:0]  y_coord = '0;
    logic        out_valid;
    logic        out_of_range;
    logic [27:0] hc_index;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cmac_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_coord(x_coord), .y_coord(y_coord),
        .out_valid(out_valid), .out_of_range(out_of_range), .hc_index(hc_index)
    );

    function automatic int model_idx(input int x, input int y, input int layer);
        int bx = (x + layer - 1) / 4;
        int by = (y + layer - 1) / 4;
        return bx + 5 * by + 25 * (layer - 1);
    endfunction

    function automatic int field(input int layer);
        return int'(hc_index[7*(layer-1) +: 7]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one valid input for one cycle; outputs are then sampled.
    task automatic apply(input int x, input int y);
        @(negedge clk);
        x_coord  = 5'(x);
        y_coord  = 5'(y);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_all(input string req, input int x, input int y);
        for (int l = 1; l <= 4; l++) check(req, field(l), model_idx(x, y, l));
    endtask

    task automatic t_reset();
        // R9: the outputs are cleared after reset.
        check("R9 valid", int'(out_valid), 0);
        check("R9 index", int'(hc_index), 0);
        check("R9 flag", int'(out_of_range), 0);
    endtask

    task automatic t_examples();
        apply(9, 0);
        check("R4 (9,0) L1", field(1), 2);  check("R4 (9,0) L2", field(2), 27);
        check("R4 (9,0) L3", field(3), 52); check("R4 (9,0) L4", field(4), 78);
        apply(9, 1);
        check("R4 (9,1) L3", field(3), 52); check("R4 (9,1) L4", field(4), 83);
        apply(9, 2);
        check("R4 (9,2) L1", field(1), 2);  check("R4 (9,2) L2", field(2), 27);
        check("R4 (9,2) L3", field(3), 57); check("R4 (9,2) L4", field(4), 83);
    endtask

    task automatic t_corners();
        apply(0, 0);
        check("R5 low L1", field(1), 0);  check("R5 low L2", field(2), 25);
        check("R5 low L3", field(3), 50); check("R5 low L4", field(4), 75);
        apply(16, 16);
        check("R5 high L1", field(1), 24); check("R5 high L2", field(2), 49);
        check("R5 high L3", field(3), 74); check("R5 high L4", field(4), 99);
    endtask

    task automatic t_sweep();
        // R1 R2 R3: every in-range coordinate against the division model.
        for (int x = 0; x <= 16; x++) begin
            for (int y = 0; y <= 16; y++) begin
                apply(x, y);
                check_all("R1 R2 sweep", x, y);
                for (int l = 1; l <= 4; l++) begin
                    check("R3 region", int'((field(l) >= 25*(l-1)) && (field(l) < 25*l)), 1);
                end
                check("R6 in range", int'(out_of_range), 0);
            end
        end
    endtask

    task automatic t_range();
        apply(17, 3);
        check("R6 x high", int'(out_of_range), 1);
        apply(3, 17);
        check("R6 y high", int'(out_of_range), 1);
        apply(31, 31);
        check("R6 both high", int'(out_of_range), 1);
        apply(16, 0);
        check("R6 edge clear", int'(out_of_range), 0);
    endtask

    task automatic t_latency();
        // R7: back-to-back valid inputs, each one cycle later.
        @(negedge clk);
        x_coord = 5'd4; y_coord = 5'd8; in_valid = 1'b1;
        @(negedge clk);
        check("R7 first valid", int'(out_valid), 1);
        check_all("R7 first data", 4, 8);
        x_coord = 5'd13; y_coord = 5'd1;
        @(negedge clk);
        check("R7 second valid", int'(out_valid), 1);
        check_all("R7 second data", 13, 1);
        in_valid = 1'b0;
        @(negedge clk);
        check("R7 valid drops", int'(out_valid), 0);
    endtask

    task automatic t_hold();
        // R8: inputs change while in_valid is low and the outputs must hold.
        apply(6, 11);
        x_coord = 5'd20; y_coord = 5'd2;
        @(negedge clk);
        @(negedge clk);
        check("R8 valid low", int'(out_valid), 0);
        check_all("R8 index held", 6, 11);
        check("R8 flag held", int'(out_of_range), 0);
    endtask

    initial begin : watchdog
        #(5ns * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_examples();
        t_corners();
        t_sweep();
        t_range();
        t_latency();
        t_hold();
        // R9: a reset applied in the middle of operation clears the outputs.
        apply(16, 16);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule